// File: doc/BRIEF.md
# FPGA configuration control sequencer

This block is the control state machine that runs the handshake around loading a programmable device. A power-on reset or a falling edge on an active-low program request starts the same sequence. The block pulls a shared open-drain init line low and wipes the configuration memory for a fixed number of cycles. It then lets go of the init line and waits until that line really reads high. Some other agent on the board may still be holding it down to delay configuration. Once the line is high, the block runs the configuration phase. Completion and error arrive as simple flags. The bitstream data paths and JTAG itself are not part of the block.

During configuration the init line takes a second job and becomes an error indicator. A configuration error drives it low again and parks the block in an error state. Only a new program edge or a power-on reset leaves that state. The done line rises only after configuration completes, and then only while both the init line and the program request read high. A 3-bit mode select is captured each time a sequence starts. Its value decides whether a program edge can restart the device at all: in SPI mode only a power-on reset can.

The program request and the sensed init line each pass through a two-stage synchronizer. The program falling edge is found on the synchronized copy.

States and transitions:
- RESET goes to CLEAR on power-on reset release.
- CLEAR goes to WAIT_INIT when the clear count has expired and the program request is high.
- WAIT_INIT goes to CONFIG when the init line is sensed high.
- CONFIG goes to ERROR on a configuration error.
- CONFIG goes to USER when the done bit is set and the init line is high.
- A qualified program edge takes every state except RESET back to CLEAR.

Top module: `cfg_seq_top`

## Requirements
- R1: A falling edge on `prog_n`, once synchronized, starts a new sequence: `state_o` shows CLEAR three clock edges after `prog_n` is sampled low. This holds from any state except RESET.
- R2: While `jtag_act` is high, a falling edge on `prog_n` has no effect on the state or on the latched mode.
- R3: After power-on reset is released, the first clock edge moves the block from RESET to CLEAR. In CLEAR, `init_drive_low` and `mem_clear` are both 1.
- R4: CLEAR lasts exactly CLEAR_CYCLES cycles when the program request is high. It lasts for as long as the synchronized program request stays low, and `init_drive_low` stays 1 throughout.
- R5: In WAIT_INIT the block releases `init_drive_low` and stays in WAIT_INIT while the sensed init line is low. It enters CONFIG three clock edges after the line is seen high.
- R6: A `cfg_err` in CONFIG moves the block to ERROR on the next edge, and ERROR drives `init_drive_low`. ERROR is left only by a qualified program edge or a power-on reset. `cfg_err` is ignored in every state other than CONFIG.
- R7: `done_out` is 0 in every state except USER. In USER it is 1 only while the synchronized init line and program request are both high. CONFIG moves to USER when `cfg_done_bit` is 1 and the init line is high.
- R8: `mode_o` takes the value of `mode_sel` on power-on reset release and on every qualified program edge, and holds that value at all other times.
- R9: When the latched mode is 3'b010 (SPI), program edges are ignored in every state. Only a power-on reset restarts the sequence.
- R10: State encoding on `state_o`: RESET=0, CLEAR=1, WAIT_INIT=2, CONFIG=3, ERROR=4, USER=5.
- R11: While reset is asserted, the state is RESET, `init_drive_low` is 1, and `mem_clear` and `done_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; its release starts a sequence |
| prog_n | input | 1 | Asynchronous active-low program request |
| jtag_act | input | 1 | High while JTAG owns the device; blocks program edges |
| init_sense | input | 1 | Asynchronous level read back from the open-drain init line |
| cfg_err | input | 1 | Configuration error flag |
| cfg_done_bit | input | 1 | Configuration complete (done bit set) |
| mode_sel | input | 3 | Configuration mode select |
| init_drive_low | output | 1 | Open-drain enable that pulls the init line low |
| done_out | output | 1 | Done line |
| mem_clear | output | 1 | Configuration memory clear strobe |
| state_o | output | 3 | Current state (R10 encoding) |
| mode_o | output | 3 | Latched configuration mode |

## Verification
The bench sweeps all eight mode codes, each with JTAG active and with JTAG inactive. For each case it fires a program edge from USER and checks the restart decision and the mode that gets latched. A design that tested the new `mode_sel` instead of the latched mode, or that let JTAG through, would restart when it must not, or would overwrite `mode_o`.

The bench counts the cycles of CLEAR exactly and holds the program request low to stretch CLEAR. It also holds the init line low from outside, both during WAIT_INIT and during USER. A design that skipped the sensed-line wait would move to CONFIG while the line was held low. A design that derived done from the state alone would keep `done_out` high while the line was held low.

The error state is driven in both a non-SPI and an SPI mode. A design that let ERROR time out, or that took `cfg_err` outside CONFIG, would leave ERROR on its own or drop into ERROR from USER.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int MODE_W  = 3;
    localparam int STATE_W = 3;

    // Latched mode value that blocks program-edge restarts
    localparam logic [MODE_W-1:0] MODE_SPI = 3'b010;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET     = 3'd0,
        ST_CLEAR     = 3'd1,
        ST_WAIT_INIT = 3'd2,
        ST_CONFIG    = 3'd3,
        ST_ERROR     = 3'd4,
        ST_USER      = 3'd5
    } cfg_state_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= RST_VAL;
            end
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
    parameter int CLEAR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic done
);

    localparam int CW = (CLEAR_CYCLES < 2) ? 1 : $clog2(CLEAR_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the count never passes its last value
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R4: a running, unfinished count advances by one each cycle
    p_count_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !done) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_s,
    input  logic              init_s,
    input  logic              jtag_act,
    input  logic              cfg_err,
    input  logic              cfg_done_bit,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              clr_done,
    output logic              clr_run,
    output logic              clr_restart,
    output logic              init_drive_low,
    output logic              mem_clear,
    output logic              done_out,
    output cfg_state_e        state_o,
    output logic [MODE_W-1:0] mode_o
);

    cfg_state_e        state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic              prog_q;
    logic              prog_fall;
    logic              edge_ok;

    assign prog_fall = prog_q & ~prog_s;
    assign edge_ok   = prog_fall & ~jtag_act & (mode_q != MODE_SPI)
                     & (state_q != ST_RESET);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (edge_ok) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_RESET:     state_d = ST_CLEAR;
                ST_CLEAR:     if (clr_done && prog_s) state_d = ST_WAIT_INIT;
                ST_WAIT_INIT: if (init_s) state_d = ST_CONFIG;
                ST_CONFIG: begin
                    if (cfg_err)                     state_d = ST_ERROR;
                    else if (cfg_done_bit && init_s) state_d = ST_USER;
                end
                ST_ERROR:     state_d = ST_ERROR;
                ST_USER:      state_d = ST_USER;
                default:      state_d = ST_RESET;
            endcase
        end
    end

    // State register, program edge history and mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            prog_q  <= 1'b1;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            prog_q  <= prog_s;
            if ((state_q == ST_RESET) || edge_ok) begin
                mode_q <= mode_sel;
            end
        end
    end

    // Outputs
    always_comb begin
        init_drive_low = 1'b0;
        mem_clear      = 1'b0;
        done_out       = 1'b0;
        unique case (state_q)
            ST_RESET:     init_drive_low = 1'b1;
            ST_CLEAR: begin
                init_drive_low = 1'b1;
                mem_clear      = 1'b1;
            end
            ST_WAIT_INIT: ;
            ST_CONFIG:    ;
            ST_ERROR:     init_drive_low = 1'b1;
            ST_USER:      done_out = prog_s & init_s;
            default:      init_drive_low = 1'b1;
        endcase
    end

    assign clr_run     = (state_q == ST_CLEAR);
    assign clr_restart = edge_ok;
    assign state_o     = state_q;
    assign mode_o      = mode_q;

    p_prog_edge_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ok |=> (state_q == ST_CLEAR));

    p_jtag_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_act && prog_fall && state_q == ST_USER) |=> (state_q == ST_USER));

    p_por_enters_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET) |=> (state_q == ST_CLEAR));

    p_prog_low_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && !prog_s) |=> (state_q == ST_CLEAR && init_drive_low));

    p_wait_for_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_INIT && !init_s && !edge_ok) |=> (state_q == ST_WAIT_INIT));

    p_error_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIG && cfg_err && !edge_ok) |=> (state_q == ST_ERROR && init_drive_low));

    p_error_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERROR && !edge_ok) |=> (state_q == ST_ERROR));

    p_done_only_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_USER) |-> !done_out);

    p_mode_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RESET && !edge_ok) |=> $stable(mode_q));

    p_spi_ignores_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SPI && state_q == ST_USER && prog_fall) |=> (state_q == ST_USER));

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
    import cfg_seq_pkg::*;
#(
    parameter int CLEAR_CYCLES = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_n,
    input  logic                jtag_act,
    input  logic                init_sense,
    input  logic                cfg_err,
    input  logic                cfg_done_bit,
    input  logic [MODE_W-1:0]   mode_sel,
    output logic                init_drive_low,
    output logic                done_out,
    output logic                mem_clear,
    output logic [STATE_W-1:0]  state_o,
    output logic [MODE_W-1:0]   mode_o
);

    logic [1:0] raw_in;
    logic [1:0] sync_out;
    logic       prog_s;
    logic       init_s;
    logic       clr_run;
    logic       clr_restart;
    logic       clr_done;
    cfg_state_e state;

    assign raw_in = {init_sense, prog_n};
    assign prog_s = sync_out[0];
    assign init_s = sync_out[1];

    // Program request resets to idle-high, sensed init line to low
    cfg_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    cfg_clear_timer #(
        .CLEAR_CYCLES (CLEAR_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (clr_run),
        .restart (clr_restart),
        .done    (clr_done)
    );

    cfg_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_s         (prog_s),
        .init_s         (init_s),
        .jtag_act       (jtag_act),
        .cfg_err        (cfg_err),
        .cfg_done_bit   (cfg_done_bit),
        .mode_sel       (mode_sel),
        .clr_done       (clr_done),
        .clr_run        (clr_run),
        .clr_restart    (clr_restart),
        .init_drive_low (init_drive_low),
        .mem_clear      (mem_clear),
        .done_out       (done_out),
        .state_o        (state),
        .mode_o         (mode_o)
    );

    assign state_o = state;

    // R11: held in reset, init is pulled low and nothing else is active
    p_reset_outputs_r11: assert property (@(posedge clk)
        !rst_n |-> (init_drive_low && !mem_clear && !done_out));

endmodule

// File: tb/cfg_seq_top_tb.sv
module cfg_seq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLR_N      = 8;
    localparam int SPI        = 2;

    localparam int S_RESET = 0, S_CLEAR = 1, S_WAIT = 2,
                   S_CONFIG = 3, S_ERROR = 4, S_USER = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_n = 1'b1;
    logic       jtag_act = 1'b0;
    logic       ext_hold = 1'b0;
    logic       init_sense;
    logic       cfg_err = 1'b0;
    logic       cfg_done_bit = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       init_drive_low;
    logic       done_out;
    logic       mem_clear;
    logic [2:0] state_o;
    logic [2:0] mode_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Open-drain wire: low when either side pulls
    assign init_sense = ~(init_drive_low | ext_hold);

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_seq_top #(.CLEAR_CYCLES(CLR_N)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_n         (prog_n),
        .jtag_act       (jtag_act),
        .init_sense     (init_sense),
        .cfg_err        (cfg_err),
        .cfg_done_bit   (cfg_done_bit),
        .mode_sel       (mode_sel),
        .init_drive_low (init_drive_low),
        .done_out       (done_out),
        .mem_clear      (mem_clear),
        .state_o        (state_o),
        .mode_o         (mode_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic por(input int m);
        @(negedge clk);
        rst_n = 1'b0;
        prog_n = 1'b1;
        jtag_act = 1'b0;
        ext_hold = 1'b0;
        cfg_err = 1'b0;
        mode_sel = 3'(m);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_state(input int s, input string tag);
        int n = 0;
        while (state_o != 3'(s) && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(tag, state_o, s);
    endtask

    task automatic pulse_prog_check(input int exp_state, input string tag);
        prog_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tag, state_o, exp_state);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (2) @(negedge clk);
        chk("R11 state", state_o, S_RESET);
        chk("R11 init drive", init_drive_low, 1);
        chk("R11 mem_clear", mem_clear, 0);
        chk("R11 done", done_out, 0);

        // R3/R8 power-on release with external hold on init
        mode_sel = 3'd1;
        ext_hold = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 state", state_o, S_CLEAR);
        chk("R10 clear code", state_o, 1);
        chk("R3 init drive", init_drive_low, 1);
        chk("R3 mem_clear", mem_clear, 1);
        chk("R8 mode at POR", mode_o, 1);
        begin
            int n = 0;
            while (state_o == 3'(S_CLEAR) && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk("R4 clear length", n, CLR_N);
        end
        chk("R5 wait entered", state_o, S_WAIT);
        chk("R5 init released", init_drive_low, 0);
        repeat (20) @(negedge clk);
        chk("R5 held by external", state_o, S_WAIT);
        ext_hold = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R5 not yet config", state_o, S_WAIT);
        @(negedge clk);
        chk("R5 config after 3 edges", state_o, S_CONFIG);
        chk("R7 done low in config", done_out, 0);

        // R6 error ignored outside CONFIG? first reach USER
        cfg_done_bit = 1'b1;
        @(negedge clk);
        chk("R7 user entered", state_o, S_USER);
        chk("R7 done high", done_out, 1);
        cfg_err = 1'b1;
        repeat (3) @(negedge clk);
        cfg_err = 1'b0;
        chk("R6 err ignored in user", state_o, S_USER);
        ext_hold = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 done drops with init held", done_out, 0);
        chk("R7 stays user", state_o, S_USER);
        ext_hold = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 done back", done_out, 1);

        // R1 R4: program held low stretches CLEAR
        mode_sel = 3'd4;
        pulse_prog_check(S_CLEAR, "R1 restart from user");
        chk("R8 mode on edge", mode_o, 4);
        repeat (30) @(negedge clk);
        chk("R4 held while prog low", state_o, S_CLEAR);
        chk("R4 init driven while prog low", init_drive_low, 1);
        prog_n = 1'b1;
        wait_state(S_USER, "R1 back to user");

        // Sweep: every mode, JTAG on/off
        for (int m = 0; m < 8; m++) begin
            for (int j = 0; j < 2; j++) begin
                bit restart;
                int newm;
                por(m);
                cfg_done_bit = 1'b1;
                wait_state(S_USER, "R3 sweep reach user");
                chk("R8 sweep POR mode", mode_o, m);
                restart = (j == 0) && (m != SPI);
                newm = (m + 3) % 8;
                jtag_act = j[0];
                mode_sel = 3'(newm);
                if (j == 1)
                    pulse_prog_check(restart ? S_CLEAR : S_USER, "R2 sweep jtag state");
                else if (m == SPI)
                    pulse_prog_check(restart ? S_CLEAR : S_USER, "R9 sweep spi state");
                else
                    pulse_prog_check(restart ? S_CLEAR : S_USER, "R1 sweep restart state");
                chk("R8 sweep latched mode", mode_o, restart ? newm : m);
                prog_n = 1'b1;
                repeat (4) @(negedge clk);
                jtag_act = 1'b0;
            end
        end

        // R6 error in a non-SPI mode, left by program edge
        por(0);
        cfg_done_bit = 1'b0;
        wait_state(S_CONFIG, "R6 reach config");
        cfg_err = 1'b1;
        @(negedge clk);
        cfg_err = 1'b0;
        chk("R6 error entered", state_o, S_ERROR);
        chk("R10 error code", state_o, 4);
        chk("R6 init driven on error", init_drive_low, 1);
        repeat (20) @(negedge clk);
        chk("R6 error sticky", state_o, S_ERROR);
        pulse_prog_check(S_CLEAR, "R6 error left by prog");
        prog_n = 1'b1;

        // R9 error in SPI mode: only POR leaves
        por(SPI);
        wait_state(S_CONFIG, "R9 reach config");
        cfg_err = 1'b1;
        @(negedge clk);
        cfg_err = 1'b0;
        chk("R9 spi error", state_o, S_ERROR);
        pulse_prog_check(S_ERROR, "R9 spi prog ignored in error");
        prog_n = 1'b1;
        por(0);
        chk("R9 POR leaves error", state_o, S_CLEAR);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule